// File: doc/BRIEF.md
# Camera Serial Link Packet Parser

This block sits behind the lane aligner of a camera serial receiver. Each byte-clock cycle it takes one byte from every data lane. Lane 0 always holds the earliest byte of the word. The parser finds the four-byte packet header at the start of each burst. Short packets become single-cycle frame-start and frame-end strobes. For long packets that carry raw pixels, the header and the two-byte footer are removed and the payload bytes are passed downstream untouched.

The output qualifier is asserted only for words that begin inside the byte count declared in the header. The footer is therefore never forwarded. Long packets of any other data type are swallowed without output. The parser also reports which raw pixel width (10, 12 or 14 bits) the most recent pixel packet used. Downstream unpacking can then adapt without reconfiguration.

A burst ends when the input qualifier falls. The parser then waits for the next header. Bytes seen inside a burst are never taken as a header.

Top module: `cam_pkt_parser`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, `out_valid`, `frame_start` and `frame_end` are 0 and `raw_width` is 0.
- R2: A header is byte 0 = identifier, bytes 1 and 2 = word count (byte 1 is the low byte, byte 2 the high byte), and byte 3 = check byte. In the identifier, bits 5:0 are the data type and bits 7:6 are a channel tag that is ignored. With 4 lanes the header is the first valid word, with lane 0 holding byte 0. With 2 lanes it spans the first two valid words.
- R3: Data types 0x00 to 0x0F are short packets and carry no payload. Data types 0x10 to 0x3F are long packets.
- R4: Data type 0x00 gives a `frame_start` pulse and 0x01 gives a `frame_end` pulse. Each pulse is exactly one cycle long and appears on the cycle after the header's last word is accepted. No other data type gives either pulse.
- R5: For data types 0x2B, 0x2C and 0x2D, every forwarded payload word appears on `out_data` one cycle after it is accepted, with the same bytes in the same lanes.
- R6: A payload word is forwarded (`out_valid`=1) only if `in_valid` is 1 and fewer payload bytes than the word count came before it in the packet. The footer and anything beyond it are never forwarded. A word count of 0 forwards nothing.
- R7: `raw_width` reports 1 for data type 0x2B, 2 for 0x2C and 3 for 0x2D, from the cycle after that header onward. Any other header leaves it unchanged.
- R8: Long packets of any non-raw data type give no `out_valid` at all.
- R9: When `in_valid` falls, the parser returns to header search, and the next valid word is decoded as a header. Bytes inside a burst are never decoded as a header, so they raise no frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | byte clock |
| rst_n | input | 1 | asynchronous active-low reset |
| in_valid | input | 1 | lane-aligned word qualifier, high through a burst |
| in_data | input | LANES*8 | one byte per lane, lane 0 in bits 7:0 |
| out_valid | output | 1 | payload word qualifier |
| out_data | output | LANES*8 | payload word, same lane order as input |
| frame_start | output | 1 | one-cycle frame start strobe |
| frame_end | output | 1 | one-cycle frame end strobe |
| raw_width | output | 2 | 0 none yet, 1 RAW10, 2 RAW12, 3 RAW14 |

## Verification
If the parser state is wrong, a header is taken from inside a payload, or a real header is missed. This shows on the next cycle: a stray frame strobe, a missing one, or the wrong `raw_width`. If the byte counter is wrong, `out_valid` stays high over a footer word or drops early. This shows one cycle after the word at the count boundary, and that is where the bench compares qualifier and data word by word. Every data type, word counts on both sides of each lane boundary, a count above 255, and an interrupted burst are all driven.

// File: rtl/cam_pkt_pkg.sv
package cam_pkt_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PAY  = 2'd1,
    ST_SKIP = 2'd2
  } parse_state_t;

  localparam logic [5:0] DT_FRAME_START = 6'h00;
  localparam logic [5:0] DT_FRAME_END   = 6'h01;
  localparam logic [5:0] DT_LONG_FIRST  = 6'h10;
  localparam logic [5:0] DT_RAW10       = 6'h2B;
  localparam logic [5:0] DT_RAW12       = 6'h2C;
  localparam logic [5:0] DT_RAW14       = 6'h2D;

  function automatic logic is_raw(input logic [5:0] dt);
    return (dt == DT_RAW10) || (dt == DT_RAW12) || (dt == DT_RAW14);
  endfunction

  function automatic logic [1:0] width_code(input logic [5:0] dt);
    case (dt)
      DT_RAW10: return 2'd1;
      DT_RAW12: return 2'd2;
      DT_RAW14: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/cam_hdr_collect.sv
module cam_hdr_collect #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               search,
  input  logic               in_valid,
  input  logic [LANES*8-1:0] in_data,
  output logic               hdr_ok,
  output logic [5:0]         hdr_dt,
  output logic [15:0]        hdr_wc
);

  generate
    if (LANES == 4) begin : g_one_beat
      logic unused_bits;
      assign unused_bits = ^{in_data[31:24], in_data[7:6], clk, rst_n};
      assign hdr_ok = search && in_valid;
      assign hdr_dt = in_data[5:0];
      assign hdr_wc = {in_data[23:16], in_data[15:8]};
    end else begin : g_two_beat
      logic        half_q, half_d;
      logic [15:0] low_q;
      logic        low_en;
      logic        unused_bits;
      assign unused_bits = ^{in_data[15:8], low_q[7:6]};

      always_comb begin
        half_d = 1'b0;
        if (search && in_valid) half_d = !half_q;
      end
      assign low_en = search && in_valid && !half_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          half_q <= 1'b0;
          low_q  <= '0;
        end else begin
          half_q <= half_d;
          if (low_en) low_q <= in_data[15:0];
        end
      end

      assign hdr_ok = search && in_valid && half_q;
      assign hdr_dt = low_q[5:0];
      assign hdr_wc = {in_data[7:0], low_q[15:8]};

      AST_HDR_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ok |-> $past(search && in_valid)); // R2
    end
  endgenerate

endmodule

// File: rtl/cam_payload_gate.sv
module cam_payload_gate #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [15:0]        wc,
  input  logic               active,
  input  logic               in_valid,
  input  logic [LANES*8-1:0] in_data,
  output logic               out_valid,
  output logic [LANES*8-1:0] out_data
);

  localparam int CW = 17;
  localparam logic [CW-1:0] STEP = CW'(LANES);

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [15:0]        wc_q;
  logic               below;
  logic               ov_d;
  logic               ov_q;
  logic [LANES*8-1:0] od_q;

  assign below = cnt_q < {1'b0, wc_q};

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                           cnt_d = '0;
    else if (active && in_valid && below) cnt_d = cnt_q + STEP;
    ov_d = active && in_valid && below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wc_q  <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ov_q  <= ov_d;
      if (clear) wc_q <= wc;
      if (ov_d)  od_q <= in_data;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= {1'b0, wc_q} + (STEP - 1'b1)); // R6

  AST_FWD_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && active)); // R6

endmodule

// File: rtl/cam_pkt_parser.sv
module cam_pkt_parser
  import cam_pkt_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [LANES*8-1:0] in_data,
  output logic               out_valid,
  output logic [LANES*8-1:0] out_data,
  output logic               frame_start,
  output logic               frame_end,
  output logic [1:0]         raw_width
);

  parse_state_t state_q, state_d;
  logic         hdr_ok;
  logic [5:0]   hdr_dt;
  logic [15:0]  hdr_wc;
  logic         fs_q, fs_d, fe_q, fe_d;
  logic [1:0]   rw_q, rw_d;
  logic         take_pix;

  cam_hdr_collect #(.LANES(LANES)) i_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .search   (state_q == ST_HUNT),
    .in_valid (in_valid),
    .in_data  (in_data),
    .hdr_ok   (hdr_ok),
    .hdr_dt   (hdr_dt),
    .hdr_wc   (hdr_wc)
  );

  assign take_pix = (hdr_dt >= DT_LONG_FIRST) && is_raw(hdr_dt);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_HUNT: if (hdr_ok) state_d = take_pix ? ST_PAY : ST_SKIP;
      ST_PAY,
      ST_SKIP: if (!in_valid) state_d = ST_HUNT;
      default: state_d = ST_HUNT;
    endcase
    fs_d = hdr_ok && (hdr_dt == DT_FRAME_START);
    fe_d = hdr_ok && (hdr_dt == DT_FRAME_END);
    rw_d = rw_q;
    if (hdr_ok && take_pix) rw_d = width_code(hdr_dt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      fs_q    <= 1'b0;
      fe_q    <= 1'b0;
      rw_q    <= 2'd0;
    end else begin
      state_q <= state_d;
      fs_q    <= fs_d;
      fe_q    <= fe_d;
      rw_q    <= rw_d;
    end
  end

  cam_payload_gate #(.LANES(LANES)) i_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (hdr_ok),
    .wc        (hdr_wc),
    .active    (state_q == ST_PAY),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assign frame_start = fs_q;
  assign frame_end   = fe_q;
  assign raw_width   = rw_q;

  AST_SYNC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && frame_end)); // R4

  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start); // R4

  AST_FE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end); // R4

  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(raw_width) |-> $past(hdr_ok)); // R7

  AST_QUIET_OFF_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_PAY) |=> !out_valid); // R8

  AST_NO_SYNC_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(frame_start || frame_end)); // R9

endmodule

// File: tb/test_cam_pkt_parser.sv
module test_cam_pkt_parser;

  localparam int L = 4;
  localparam int W = L * 8;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         frame_start;
  logic         frame_end;
  logic [1:0]   raw_width;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [1:0] exp_w;

  cam_pkt_parser #(.LANES(L)) i_cam_pkt_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .frame_start(frame_start), .frame_end(frame_end), .raw_width(raw_width)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [1:0] wcode(input logic [5:0] dt);
    if (dt == 6'h2B) return 2'd1;
    if (dt == 6'h2C) return 2'd2;
    if (dt == 6'h2D) return 2'd3;
    return 2'd0;
  endfunction

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R9 idle out_valid", out_valid, 0);
  endtask

  // Sends a packet; maxw limits the number of payload words (burst cut short).
  task automatic send(input logic [5:0] dt, input logic [1:0] vc,
                      input int wc, input int maxw, input int seed);
    bit long_pkt;
    bit raw;
    int nwords;
    logic [W-1:0] word;
    long_pkt = dt >= 6'h10;
    raw = wcode(dt) != 2'd0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = {8'h5A, wc[15:8], wc[7:0], vc, dt};
    @(posedge clk); #1;
    if (raw) exp_w = wcode(dt);
    check(frame_start == (dt == 6'h00), "R4 frame_start", frame_start, dt == 6'h00);
    check(frame_end == (dt == 6'h01), "R4 frame_end", frame_end, dt == 6'h01);
    check(raw_width == exp_w, "R7 raw_width", raw_width, exp_w);
    if (long_pkt) begin
      nwords = (wc + 2 + L - 1) / L;
      if (nwords > maxw) nwords = maxw;
      for (int j = 0; j < nwords; j++) begin
        bit ev;
        for (int i = 0; i < L; i++) begin
          int k;
          k = j * L + i;
          word[i*8 +: 8] = (k == 0) ? 8'h00 : 8'((seed + k * 37) ^ (k >> 3));
        end
        @(negedge clk);
        in_data = word;
        @(posedge clk); #1;
        ev = raw && (j * L < wc);
        if (raw) check(out_valid == ev, "R6 out_valid gate", out_valid, ev);
        else     check(out_valid == 1'b0, "R8 non-raw silent", out_valid, 0);
        if (ev) check(out_data == word, "R5 payload bytes", out_data, word);
        check(!frame_start && !frame_end, "R9 no sync inside burst",
              {frame_start, frame_end}, 0);
      end
    end
    idle();
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    exp_w = 2'd0;
    @(posedge clk); #1;
    check({out_valid, frame_start, frame_end, raw_width} == 0, "R1 in reset",
          {out_valid, frame_start, frame_end, raw_width}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check({out_valid, frame_start, frame_end, raw_width} == 0, "R1 after release",
          {out_valid, frame_start, frame_end, raw_width}, 0);

    // R2 R3 R4 R8: every data type, nonzero channel tag on most
    for (int d = 0; d < 64; d++) begin
      send(6'(d), 2'((d + 1) & 3), (d % 7) + 1, 1000, d);
    end

    // R5 R6: word count sweep across lane boundaries for each raw type
    for (int t = 0; t < 3; t++) begin
      for (int wc = 0; wc < 13; wc++) begin
        send(6'h2B + 6'(t), 2'd0, wc, 1000, wc * 5 + t);
      end
    end

    // R2: word count with a nonzero high byte
    send(6'h2C, 2'd3, 300, 1000, 91);

    // R7: width held over short and non-raw long packets
    send(6'h2D, 2'd0, 8, 1000, 3);
    send(6'h00, 2'd0, 0, 1000, 0);
    send(6'h2A, 2'd0, 8, 1000, 4);
    check(raw_width == 2'd3, "R7 width held", raw_width, 3);

    // R9: burst cut short, next valid word is a header
    send(6'h2B, 2'd0, 40, 2, 7);
    send(6'h00, 2'd1, 0, 1000, 0);
    send(6'h01, 2'd2, 0, 1000, 0);
    send(6'h2B, 2'd0, 6, 1000, 8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule